// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block turns a logical address (a 16-bit selector paired with a 32-bit offset) into a 32-bit linear address. It keeps six segment registers. Each one holds a selector and a cached copy of the segment's base and byte limit. Software-visible paging is not part of the block. Its output is the linear address that a later paging stage would consume.

A load request names a segment register and a selector. The selector's table flag picks one of two descriptor tables: a per-task local table or a system-wide global table. Each table has a base address and an entry count supplied on input ports. The index is checked against the entry count. If it is in range, the two 32-bit words of the 8-byte descriptor are fetched through a one-request-at-a-time read port and written into the register.

A translate request names a segment register and an offset. One cycle later it returns either base plus offset or a fault code. The offset is compared with the cached limit before the sum is used.

Top module: `segxlate`

## Requirements
- R1: After reset no segment register is loaded, and `ld_busy`, `ld_done`, `xl_done` and `mem_req` are low.
- R2: The selector is decoded as index = bits [15:3], table flag = bit 2 (1 picks the local table, 0 the global table), privilege = bits [1:0].
- R3: A load with an in-range index issues exactly two reads, each a one-cycle `mem_req`. The first read is at table base + index×8 and returns the segment base. The second is at that address + 4 and returns the limit in bytes. `ld_done` follows with `ld_fault` low, and the register holds the new selector, base and limit.
- R4: A load whose index is greater than or equal to the chosen table's entry count pulses `ld_done` with `ld_fault` high one cycle after the request. It issues no read and leaves the target register unchanged. The highest in-range index (count − 1) loads normally.
- R5: A translate request with offset ≤ limit returns `xl_done` exactly one cycle later, with `xl_code` = 0 and `xl_lin` = base + offset.
- R6: An offset strictly greater than the limit returns `xl_code` = 1 (limit fault), with `xl_lin` = 0.
- R7: Translating through a register that has never been loaded returns `xl_code` = 2 (not present), with `xl_lin`, `xl_sel` and `xl_rpl` all 0.
- R8: A segment-register number of 6 or 7 gives `xl_code` = 3 (bad register) on translate. On load it gives an immediate `ld_done` with `ld_fault` high and no read.
- R9: `xl_sel` returns the stored selector unchanged and `xl_rpl` its privilege bits, on success and on a limit fault. No privilege comparison affects the result.
- R10: A load request that arrives while `ld_busy` is high is ignored and changes no register.
- R11: The base-plus-offset sum wraps modulo 2^32.

Both the limit check and the sum take the offset as an unsigned number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_base | input | 32 | Byte address of the local descriptor table |
| lcl_count | input | 14 | Number of entries in the local table |
| glb_base | input | 32 | Byte address of the global descriptor table |
| glb_count | input | 14 | Number of entries in the global table |
| ld_valid | input | 1 | Load request strobe |
| ld_seg | input | 3 | Segment register to load |
| ld_sel | input | 16 | Selector to load |
| ld_busy | output | 1 | Descriptor fetch in progress |
| ld_done | output | 1 | One-cycle pulse ending a load |
| ld_fault | output | 1 | Load was rejected; valid with `ld_done` |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| xl_valid | input | 1 | Translate request strobe |
| xl_seg | input | 3 | Segment register used for translation |
| xl_off | input | 32 | Offset within the segment |
| xl_done | output | 1 | Translate result valid |
| xl_lin | output | 32 | Linear address (0 on a fault) |
| xl_code | output | 2 | 0 ok, 1 limit, 2 not present, 3 bad register |
| xl_sel | output | 16 | Stored selector of the register used |
| xl_rpl | output | 2 | Privilege bits of that selector |

## Verification
Translations are tried with offsets of zero, exactly the limit, the limit plus one and all ones. These separate a strict comparison from an inclusive one, and the last two must fault. A segment whose base sits near the top of the address space shows whether the sum wraps. Loads use indices at count − 1 and at count in both tables, which separates a correct table choice and bound from an off-by-one error. A load that lands on a register already holding data, and a load issued during a fetch, show that rejected or ignored requests leave earlier contents in place.

// File: rtl/segxlate_pkg.sv
package segxlate_pkg;

   typedef enum logic [1:0] {
      XF_NONE   = 2'd0,
      XF_LIMIT  = 2'd1,
      XF_ABSENT = 2'd2,
      XF_BADSEG = 2'd3
   } xfault_e;

   typedef enum logic [2:0] {
      LD_IDLE  = 3'd0,
      LD_REQ0  = 3'd1,
      LD_WAIT0 = 3'd2,
      LD_REQ1  = 3'd3,
      LD_WAIT1 = 3'd4
   } ldstate_e;

endpackage

// File: rtl/segxlate_loader.sv
module segxlate_loader
   import segxlate_pkg::*;
#(
   parameter int AW   = 32,
   parameter int IDXW = 13,
   parameter int NSEG = 6,
   parameter int SEGW = 3,
   localparam int CW   = IDXW + 1,
   localparam int SELW = IDXW + 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   lcl_base,
   input  logic [CW-1:0]   lcl_count,
   input  logic [AW-1:0]   glb_base,
   input  logic [CW-1:0]   glb_count,
   input  logic            ld_valid,
   input  logic [SEGW-1:0] ld_seg,
   input  logic [SELW-1:0] ld_sel,
   output logic            ld_busy,
   output logic            ld_done,
   output logic            ld_fault,
   output logic            mem_req,
   output logic [AW-1:0]   mem_addr,
   input  logic            mem_rvalid,
   input  logic [AW-1:0]   mem_rdata,
   output logic            wr_en,
   output logic [SEGW-1:0] wr_seg,
   output logic [SELW-1:0] wr_sel,
   output logic [AW-1:0]   wr_base,
   output logic [AW-1:0]   wr_limit
);

   localparam int PADW = AW - IDXW - 3;

   ldstate_e        state_q;
   logic [AW-1:0]   addr_q;
   logic [AW-1:0]   base_q;
   logic [SEGW-1:0] seg_q;
   logic [SELW-1:0] sel_q;
   logic            done_q;
   logic            fault_q;

   // selector decode: index above, table flag at bit 2, privilege below
   logic [IDXW-1:0] req_idx;
   logic            req_local;
   logic [CW-1:0]   req_count;
   logic [AW-1:0]   req_tbase;
   logic            req_bad;

   always_comb begin
      req_idx   = ld_sel[SELW-1:3];
      req_local = ld_sel[2];
      req_count = req_local ? lcl_count : glb_count;
      req_tbase = req_local ? lcl_base : glb_base;
      req_bad   = ({1'b0, ld_seg} >= (SEGW+1)'(NSEG)) ||
                  ({1'b0, req_idx} >= req_count);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= LD_IDLE;
         addr_q  <= '0;
         base_q  <= '0;
         seg_q   <= '0;
         sel_q   <= '0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         unique case (state_q)
            LD_IDLE: begin
               if (ld_valid) begin
                  if (req_bad) begin
                     done_q  <= 1'b1;
                     fault_q <= 1'b1;
                  end else begin
                     addr_q  <= req_tbase + {{PADW{1'b0}}, req_idx, 3'b000};
                     seg_q   <= ld_seg;
                     sel_q   <= ld_sel;
                     state_q <= LD_REQ0;
                  end
               end
            end
            LD_REQ0: state_q <= LD_WAIT0;
            LD_WAIT0: begin
               if (mem_rvalid) begin
                  base_q  <= mem_rdata;
                  addr_q  <= addr_q + AW'(4);
                  state_q <= LD_REQ1;
               end
            end
            LD_REQ1: state_q <= LD_WAIT1;
            LD_WAIT1: begin
               if (mem_rvalid) begin
                  done_q  <= 1'b1;
                  state_q <= LD_IDLE;
               end
            end
            default: state_q <= LD_IDLE;
         endcase
      end
   end

   assign ld_busy  = (state_q != LD_IDLE);
   assign ld_done  = done_q;
   assign ld_fault = fault_q;
   assign mem_req  = (state_q == LD_REQ0) || (state_q == LD_REQ1);
   assign mem_addr = addr_q;

   assign wr_en    = (state_q == LD_WAIT1) && mem_rvalid;
   assign wr_seg   = seg_q;
   assign wr_sel   = sel_q;
   assign wr_base  = base_q;
   assign wr_limit = mem_rdata;

endmodule

// File: rtl/segxlate_segfile.sv
module segxlate_segfile #(
   parameter int AW   = 32,
   parameter int SELW = 16,
   parameter int NSEG = 6,
   parameter int SEGW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [SEGW-1:0] wr_seg,
   input  logic [SELW-1:0] wr_sel,
   input  logic [AW-1:0]   wr_base,
   input  logic [AW-1:0]   wr_limit,
   input  logic [SEGW-1:0] rd_seg,
   output logic            rd_valid,
   output logic [SELW-1:0] rd_sel,
   output logic [AW-1:0]   rd_base,
   output logic [AW-1:0]   rd_limit
);

   logic [NSEG-1:0] vld_a;
   logic [SELW-1:0] sel_a   [NSEG];
   logic [AW-1:0]   base_a  [NSEG];
   logic [AW-1:0]   limit_a [NSEG];

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      logic            vld_r;
      logic [SELW-1:0] sel_r;
      logic [AW-1:0]   base_r;
      logic [AW-1:0]   limit_r;
      logic            hit;

      assign hit = wr_en && ({1'b0, wr_seg} == (SEGW+1)'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_r   <= 1'b0;
            sel_r   <= '0;
            base_r  <= '0;
            limit_r <= '0;
         end else if (hit) begin
            vld_r   <= 1'b1;
            sel_r   <= wr_sel;
            base_r  <= wr_base;
            limit_r <= wr_limit;
         end
      end

      assign vld_a[g]   = vld_r;
      assign sel_a[g]   = sel_r;
      assign base_a[g]  = base_r;
      assign limit_a[g] = limit_r;
   end

   always_comb begin
      rd_valid = 1'b0;
      rd_sel   = '0;
      rd_base  = '0;
      rd_limit = '0;
      for (int i = 0; i < NSEG; i++) begin
         if ({1'b0, rd_seg} == (SEGW+1)'(i)) begin
            rd_valid = vld_a[i];
            rd_sel   = sel_a[i];
            rd_base  = base_a[i];
            rd_limit = limit_a[i];
         end
      end
   end

endmodule

// File: rtl/segxlate_xlate.sv
module segxlate_xlate
   import segxlate_pkg::*;
#(
   parameter int AW   = 32,
   parameter int SELW = 16,
   parameter int NSEG = 6,
   parameter int SEGW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            xl_valid,
   input  logic [SEGW-1:0] xl_seg,
   input  logic [AW-1:0]   xl_off,
   input  logic            rd_valid,
   input  logic [SELW-1:0] rd_sel,
   input  logic [AW-1:0]   rd_base,
   input  logic [AW-1:0]   rd_limit,
   output logic            xl_done,
   output logic [AW-1:0]   xl_lin,
   output logic [1:0]      xl_code,
   output logic [SELW-1:0] xl_sel
);

   xfault_e         code_d;
   logic [AW-1:0]   lin_d;
   logic [SELW-1:0] sel_d;

   // limit test first; the sum is only passed on when the offset fits
   always_comb begin
      code_d = XF_NONE;
      lin_d  = '0;
      sel_d  = '0;
      if ({1'b0, xl_seg} >= (SEGW+1)'(NSEG)) begin
         code_d = XF_BADSEG;
      end else if (!rd_valid) begin
         code_d = XF_ABSENT;
      end else if (xl_off > rd_limit) begin
         code_d = XF_LIMIT;
         sel_d  = rd_sel;
      end else begin
         lin_d  = rd_base + xl_off;
         sel_d  = rd_sel;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xl_done <= 1'b0;
         xl_lin  <= '0;
         xl_code <= XF_NONE;
         xl_sel  <= '0;
      end else begin
         xl_done <= xl_valid;
         if (xl_valid) begin
            xl_lin  <= lin_d;
            xl_code <= code_d;
            xl_sel  <= sel_d;
         end
      end
   end

endmodule

// File: rtl/segxlate.sv
module segxlate #(
   parameter int AW   = 32,
   parameter int IDXW = 13,
   parameter int NSEG = 6,
   parameter int SEGW = 3,
   localparam int CW   = IDXW + 1,
   localparam int SELW = IDXW + 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   lcl_base,
   input  logic [CW-1:0]   lcl_count,
   input  logic [AW-1:0]   glb_base,
   input  logic [CW-1:0]   glb_count,
   input  logic            ld_valid,
   input  logic [SEGW-1:0] ld_seg,
   input  logic [SELW-1:0] ld_sel,
   output logic            ld_busy,
   output logic            ld_done,
   output logic            ld_fault,
   output logic            mem_req,
   output logic [AW-1:0]   mem_addr,
   input  logic            mem_rvalid,
   input  logic [AW-1:0]   mem_rdata,
   input  logic            xl_valid,
   input  logic [SEGW-1:0] xl_seg,
   input  logic [AW-1:0]   xl_off,
   output logic            xl_done,
   output logic [AW-1:0]   xl_lin,
   output logic [1:0]      xl_code,
   output logic [SELW-1:0] xl_sel,
   output logic [1:0]      xl_rpl
);

   if (NSEG < 1 || NSEG > (1 << SEGW)) begin : g_bad_nseg
      $error("segxlate: NSEG must lie in 1 .. 2**SEGW");
   end
   if (AW <= SELW) begin : g_bad_aw
      $error("segxlate: AW must exceed the selector width");
   end
   if (IDXW < 1) begin : g_bad_idxw
      $error("segxlate: IDXW must be positive");
   end

   logic            wr_en;
   logic [SEGW-1:0] wr_seg;
   logic [SELW-1:0] wr_sel;
   logic [AW-1:0]   wr_base;
   logic [AW-1:0]   wr_limit;
   logic            rd_valid;
   logic [SELW-1:0] rd_sel;
   logic [AW-1:0]   rd_base;
   logic [AW-1:0]   rd_limit;

   segxlate_loader #(.AW(AW), .IDXW(IDXW), .NSEG(NSEG), .SEGW(SEGW)) u_loader (
      .clk        (clk),
      .rst_n      (rst_n),
      .lcl_base   (lcl_base),
      .lcl_count  (lcl_count),
      .glb_base   (glb_base),
      .glb_count  (glb_count),
      .ld_valid   (ld_valid),
      .ld_seg     (ld_seg),
      .ld_sel     (ld_sel),
      .ld_busy    (ld_busy),
      .ld_done    (ld_done),
      .ld_fault   (ld_fault),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .wr_en      (wr_en),
      .wr_seg     (wr_seg),
      .wr_sel     (wr_sel),
      .wr_base    (wr_base),
      .wr_limit   (wr_limit)
   );

   segxlate_segfile #(.AW(AW), .SELW(SELW), .NSEG(NSEG), .SEGW(SEGW)) u_segfile (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_seg   (wr_seg),
      .wr_sel   (wr_sel),
      .wr_base  (wr_base),
      .wr_limit (wr_limit),
      .rd_seg   (xl_seg),
      .rd_valid (rd_valid),
      .rd_sel   (rd_sel),
      .rd_base  (rd_base),
      .rd_limit (rd_limit)
   );

   segxlate_xlate #(.AW(AW), .SELW(SELW), .NSEG(NSEG), .SEGW(SEGW)) u_xlate (
      .clk      (clk),
      .rst_n    (rst_n),
      .xl_valid (xl_valid),
      .xl_seg   (xl_seg),
      .xl_off   (xl_off),
      .rd_valid (rd_valid),
      .rd_sel   (rd_sel),
      .rd_base  (rd_base),
      .rd_limit (rd_limit),
      .xl_done  (xl_done),
      .xl_lin   (xl_lin),
      .xl_code  (xl_code),
      .xl_sel   (xl_sel)
   );

   assign xl_rpl = xl_sel[1:0];

endmodule

// File: rtl/segxlate_sva.sv
module segxlate_sva #(
   parameter int AW   = 32,
   parameter int NSEG = 6,
   parameter int SEGW = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ld_valid,
   input logic [SEGW-1:0] ld_seg,
   input logic            ld_busy,
   input logic            ld_done,
   input logic            ld_fault,
   input logic            mem_req,
   input logic            xl_valid,
   input logic [SEGW-1:0] xl_seg,
   input logic            xl_done,
   input logic [AW-1:0]   xl_lin,
   input logic [1:0]      xl_code
);

   assert_req_in_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ld_busy);

   assert_req_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   assert_xl_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      xl_valid |=> xl_done);

   assert_xl_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !xl_valid |=> !xl_done);

   assert_fault_zero_lin_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_done && xl_code != 2'd0) |-> (xl_lin == '0));

   assert_xl_badseg_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_valid && ({1'b0, xl_seg} >= (SEGW+1)'(NSEG))) |=> (xl_code == 2'd3));

   assert_ld_badseg_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && !ld_busy && ({1'b0, ld_seg} >= (SEGW+1)'(NSEG)))
      |=> (ld_done && ld_fault && !ld_busy));

   assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ld_done |-> (!mem_req && !ld_busy));

endmodule

bind segxlate segxlate_sva #(.AW(AW), .NSEG(NSEG), .SEGW(SEGW)) u_sva (
   .clk      (clk),
   .rst_n    (rst_n),
   .ld_valid (ld_valid),
   .ld_seg   (ld_seg),
   .ld_busy  (ld_busy),
   .ld_done  (ld_done),
   .ld_fault (ld_fault),
   .mem_req  (mem_req),
   .xl_valid (xl_valid),
   .xl_seg   (xl_seg),
   .xl_done  (xl_done),
   .xl_lin   (xl_lin),
   .xl_code  (xl_code)
);

// File: tb/segxlate_bench.sv
`timescale 1ns/1ps
module segxlate_bench;

   localparam logic [31:0] LCL_BASE = 32'h0010_0000;
   localparam logic [13:0] LCL_CNT  = 14'd20;
   localparam logic [31:0] GLB_BASE = 32'h0020_0000;
   localparam logic [13:0] GLB_CNT  = 14'd8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_valid = 1'b0;
   logic [2:0]  ld_seg = '0;
   logic [15:0] ld_sel = '0;
   logic        ld_busy, ld_done, ld_fault, mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        xl_valid = 1'b0;
   logic [2:0]  xl_seg = '0;
   logic [31:0] xl_off = '0;
   logic        xl_done;
   logic [31:0] xl_lin;
   logic [1:0]  xl_code;
   logic [15:0] xl_sel;
   logic [1:0]  xl_rpl;

   always #2.5 clk = ~clk;

   segxlate u_segxlate (
      .clk(clk), .rst_n(rst_n),
      .lcl_base(LCL_BASE), .lcl_count(LCL_CNT),
      .glb_base(GLB_BASE), .glb_count(GLB_CNT),
      .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel),
      .ld_busy(ld_busy), .ld_done(ld_done), .ld_fault(ld_fault),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .xl_valid(xl_valid), .xl_seg(xl_seg), .xl_off(xl_off),
      .xl_done(xl_done), .xl_lin(xl_lin), .xl_code(xl_code),
      .xl_sel(xl_sel), .xl_rpl(xl_rpl)
   );

   int n_checks = 0;
   int n_errors = 0;
   bit reported = 0;

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      end
   endtask

   // memory contents: word 0 of a descriptor is the base, word 1 the limit
   function automatic logic [31:0] memword(logic [31:0] a);
      return a[2] ? {16'h0, ~a[7:0], 8'hFF} : {~a[7:0], 24'hFFF000};
   endfunction

   int          nreq = 0;
   logic [31:0] addr_log [2];

   always @(posedge clk) begin
      mem_rvalid <= mem_req;
      mem_rdata  <= memword(mem_addr);
      if (mem_req) begin
         if (nreq < 2) addr_log[nreq] = mem_addr;
         nreq++;
      end
   end

   // reference model of the six registers
   bit          m_vld [6];
   logic [31:0] m_base [6];
   logic [31:0] m_lim [6];
   logic [15:0] m_sel [6];

   typedef struct {
      logic [31:0] lin;
      logic [1:0]  code;
      logic [15:0] sel;
      string       tag;
   } xl_item_t;

   xl_item_t exp_q [$];

   // monitor: pops one expected item for every result the design produces
   always @(negedge clk) begin
      if (rst_n && xl_done) begin
         if (exp_q.size() == 0) begin
            check("R5", "unexpected xl_done", 32'd1, 32'd0);
         end else begin
            xl_item_t it;
            it = exp_q.pop_front();
            check(it.tag, "xl_code", {30'd0, xl_code}, {30'd0, it.code});
            check(it.tag, "xl_lin", xl_lin, it.lin);
            check(it.tag, "xl_sel", {16'd0, xl_sel}, {16'd0, it.sel});
            check(it.tag, "xl_rpl", {30'd0, xl_rpl}, {30'd0, it.sel[1:0]});
         end
      end
   end

   task automatic do_xl(int seg, logic [31:0] off, string tag);
      xl_item_t it;
      it.tag = tag;
      it.lin = '0;
      it.sel = '0;
      if (seg >= 6) it.code = 2'd3;
      else if (!m_vld[seg]) it.code = 2'd2;
      else if (off > m_lim[seg]) begin
         it.code = 2'd1;
         it.sel  = m_sel[seg];
      end else begin
         it.code = 2'd0;
         it.lin  = m_base[seg] + off;
         it.sel  = m_sel[seg];
      end
      exp_q.push_back(it);
      xl_valid = 1'b1;
      xl_seg   = 3'(seg);
      xl_off   = off;
      @(negedge clk);
      xl_valid = 1'b0;
   endtask

   task automatic do_load(int seg, logic [15:0] sel, bit intrude, string tag);
      logic [12:0] idx;
      logic [13:0] cnt;
      logic [31:0] tb, a0;
      bit          bad, seen;
      idx  = sel[15:3];
      cnt  = sel[2] ? LCL_CNT : GLB_CNT;
      tb   = sel[2] ? LCL_BASE : GLB_BASE;
      bad  = (seg >= 6) || ({1'b0, idx} >= cnt);
      a0   = tb + {16'd0, idx, 3'b000};
      nreq = 0;
      ld_valid = 1'b1;
      ld_seg   = 3'(seg);
      ld_sel   = sel;
      @(negedge clk);
      ld_valid = 1'b0;
      if (intrude) begin
         ld_valid = 1'b1;
         ld_seg   = 3'd5;
         ld_sel   = 16'h0008;
         @(negedge clk);
         ld_valid = 1'b0;
      end
      seen = 0;
      for (int k = 0; k < 40; k++) begin
         if (ld_done) begin
            seen = 1;
            break;
         end
         @(negedge clk);
      end
      check(tag, "ld_done seen", {31'd0, seen}, 32'd1);
      check(tag, "ld_fault", {31'd0, ld_fault}, {31'd0, bad});
      check(tag, "read count", nreq, bad ? 0 : 2);
      if (!bad) begin
         check(tag, "first read addr", addr_log[0], a0);
         check(tag, "second read addr", addr_log[1], a0 + 32'd4);
         m_vld[seg]  = 1;
         m_base[seg] = memword(a0);
         m_lim[seg]  = memword(a0 + 32'd4);
         m_sel[seg]  = sel;
      end
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      for (int i = 0; i < 6; i++) m_vld[i] = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: quiet outputs after reset
      check("R1", "ld_busy", {31'd0, ld_busy}, 32'd0);
      check("R1", "ld_done", {31'd0, ld_done}, 32'd0);
      check("R1", "xl_done", {31'd0, xl_done}, 32'd0);
      check("R1", "mem_req", {31'd0, mem_req}, 32'd0);
      // R1, R7: nothing loaded yet
      for (int s = 0; s < 6; s++) do_xl(s, 32'h0, "R7");

      // R2, R3: global table index 3, privilege 1
      do_load(0, 16'h0019, 0, "R3");
      do_xl(0, 32'h0, "R5");
      do_xl(0, m_lim[0], "R5");
      do_xl(0, m_lim[0] + 32'd1, "R6");
      do_xl(0, 32'hFFFF_FFFF, "R6");
      do_xl(0, 32'h0000_0123, "R9");

      // R4: local index 19 fits (count 20), index 20 does not
      do_load(1, 16'h009F, 0, "R4");
      do_xl(1, m_lim[1], "R2");
      do_load(2, 16'h00A4, 0, "R4");
      do_xl(2, 32'h10, "R4");
      // R4: rejected global index 8 keeps seg 0 contents
      do_load(0, 16'h0040, 0, "R4");
      do_xl(0, 32'h40, "R4");

      // R11: base near the top of the space wraps
      do_load(3, 16'h0002, 0, "R11");
      do_xl(3, m_lim[3], "R11");
      do_xl(3, 32'h0000_1000, "R11");

      // R8: register numbers 6 and 7
      do_load(6, 16'h0008, 0, "R8");
      do_load(7, 16'h000C, 0, "R8");
      do_xl(6, 32'h0, "R8");
      do_xl(7, 32'h0, "R8");

      // R10: second load during the fetch is dropped
      do_load(4, 16'h0004, 1, "R10");
      do_xl(5, 32'h0, "R10");
      do_xl(4, 32'h8, "R10");

      // reload seg 1 from the last global entry, privilege 2
      do_load(1, 16'h003A, 0, "R3");
      do_xl(1, 32'h0, "R9");
      do_xl(1, m_lim[1] + 32'd1, "R9");

      repeat (3) @(negedge clk);
      check("R5", "pending results", exp_q.size(), 0);
      report();
      $finish;
   end

endmodule